// File: doc/BRIEF.md
# Priority-Level Interrupt Controller

This block picks one interrupt request out of a small set and offers it to a processor core. Three special requests are always checked first: a non-maskable request, a break request and a debug-port request. Behind them sits a parameterised set of maskable sources. Each maskable source has its own 4-bit priority and can be set to sense either the input level or a rising edge. The block keeps the core's 4-bit interrupt mask. A maskable request is offered only when its priority is strictly above that mask.

When a request wins, the block enters a pending phase. In that phase it raises a request towards the core, pulls an active-low indicator pin low, and shows the winner's vector number and level. The core answers with single-cycle acknowledge pulses. The first pulse accepts the request. It copies the accepted level into the mask, clears the edge latch of the winner and releases the indicator. Each further pulse moves through the exception steps: save status, save program counter, fetch vector, branch. The block then returns to idle. Software can overwrite the mask through a write strobe, for example when it returns from an exception.

Top module: `prio_irq_ctrl`

## Requirements
- R1: The fixed order of precedence is: non-maskable first, then break, then debug, then maskable sources from the highest level down.
- R2: A pending non-maskable request is offered whatever the mask value, including a mask of 15.
- R3: A maskable source at level n is offered only while the mask is below n. Break and debug requests are offered only while the mask is below 15.
- R4: The first acknowledge in the pending phase copies the accepted level into the mask. The level is 15 for any special request. Power-on reset and manual reset both set the mask to 15.
- R5: `phase_o` uses the encoding 0 idle, 1 pending, 2 save status, 3 save program counter, 4 fetch vector, 5 branch. From phase 1, each acknowledge pulse advances the phase by one step, and phase 5 returns to 0. An acknowledge in idle has no effect.
- R6: `irq_n_o` is low exactly while the phase is pending, together with `cpu_req_o`. It is high again in the cycle after the accepting acknowledge.
- R7: If a stronger request appears while a request is pending, the shown vector and level switch to it, and `irq_n_o` stays low throughout.
- R8: A rising edge on an edge-sensed source, or on the non-maskable input, latches a request that outlives the input pulse. The latch is cleared by its acceptance, by the manual reset `mrst_i`, and by power-on reset.
- R9: A level-sensed source is never latched. Dropping its input while pending returns the block to idle.
- R10: Among maskable sources with equal level, the lowest source index wins.
- R11: The vector numbers are 11 for non-maskable, 12 for break, 13 for debug, and 64 + i for maskable source i.
- R12: A source programmed to level 0 is never offered.
- R13: A mask write in any cycle other than the accepting acknowledge updates `mask_o` at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| mrst_i | input | 1 | Synchronous manual reset, active high |
| nmi_i | input | 1 | Non-maskable request, rising-edge sensed |
| brk_i | input | 1 | Break request, level sensed |
| dbg_i | input | 1 | Debug-port request, level sensed |
| src_i | input | NSRC | Maskable request inputs |
| src_edge_i | input | NSRC | Per source: 1 = rising-edge sensing, 0 = level sensing |
| src_prio_i | input | NSRC*LVLW | Per-source priority level |
| mask_we_i | input | 1 | Mask write strobe |
| mask_wdata_i | input | LVLW | Mask write value |
| cpu_ack_i | input | 1 | Core acknowledge pulse |
| cpu_req_o | output | 1 | Request offered to the core |
| irq_n_o | output | 1 | Active-low request indicator |
| vec_o | output | VECW | Vector number of the offered or accepted request |
| lvl_o | output | LVLW | Level of the offered or accepted request |
| mask_o | output | LVLW | Current interrupt mask |
| phase_o | output | 3 | Handshake phase |

## Verification
The hardest case to reach is a stronger request taking over while a weaker one is still pending. The indicator must stay low and only the vector may change. The stimulus reaches this case in two ways. In the first, a break request and a non-maskable edge arrive together: the break, sensed by level, wins one cycle before the edge latch is set, and the non-maskable request then replaces it. In the second, a second level source is raised while the first is pending. Edge latches are also checked after the input has fallen: first before any clearing, then after the accepting acknowledge, then after each of the two resets.

// File: rtl/pic_pkg.sv
package pic_pkg;

    typedef enum logic [2:0] {
        PH_IDLE    = 3'd0,
        PH_PEND    = 3'd1,
        PH_SAVE_SR = 3'd2,
        PH_SAVE_PC = 3'd3,
        PH_FETCH   = 3'd4,
        PH_BRANCH  = 3'd5
    } phase_e;

endpackage

// File: rtl/pic_edge_latch.sv
module pic_edge_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic mrst_i,
    input  logic in_i,
    input  logic is_edge_i,
    input  logic clr_i,
    output logic pend_o
);

    logic prev_d, prev_q;
    logic hold_d, hold_q;

    always_comb begin
        prev_d = in_i;
        hold_d = (hold_q & ~clr_i) | (in_i & ~prev_q & is_edge_i);
        if (mrst_i) begin
            hold_d = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            hold_q <= 1'b0;
        end else begin
            prev_q <= prev_d;
            hold_q <= hold_d;
        end
    end

    assign pend_o = is_edge_i ? hold_q : in_i;

endmodule

// File: rtl/pic_arbiter.sv
module pic_arbiter #(
    parameter int NSRC     = 4,
    parameter int LVLW     = 4,
    parameter int VECW     = 8,
    parameter int VEC_NMI  = 11,
    parameter int VEC_BRK  = 12,
    parameter int VEC_DBG  = 13,
    parameter int VEC_BASE = 64
) (
    input  logic                       nmi_i,
    input  logic                       brk_i,
    input  logic                       dbg_i,
    input  logic [NSRC-1:0]            pend_i,
    input  logic [NSRC-1:0][LVLW-1:0]  prio_i,
    input  logic [LVLW-1:0]            mask_i,
    output logic                       win_o,
    output logic [VECW-1:0]            vec_o,
    output logic [LVLW-1:0]            lvl_o,
    output logic [NSRC:0]              clr_o
);

    localparam int LMAX = (1 << LVLW) - 1;

    logic                found;
    logic [LVLW-1:0]     best_lvl;
    logic [VECW-1:0]     best_vec;
    logic [NSRC:0]       best_clr;
    logic                top_open;

    always_comb begin
        found    = 1'b0;
        best_lvl = '0;
        best_vec = '0;
        best_clr = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (pend_i[i] && (prio_i[i] != '0) && (!found || prio_i[i] >= best_lvl)) begin
                found    = 1'b1;
                best_lvl = prio_i[i];
                best_vec = VECW'(VEC_BASE + i);
                best_clr = '0;
                best_clr[i] = 1'b1;
            end
        end
    end

    assign top_open = (mask_i < LVLW'(LMAX));

    always_comb begin
        win_o = 1'b0;
        vec_o = '0;
        lvl_o = '0;
        clr_o = '0;
        if (nmi_i) begin
            win_o       = 1'b1;
            vec_o       = VECW'(VEC_NMI);
            lvl_o       = LVLW'(LMAX);
            clr_o[NSRC] = 1'b1;
        end else if (brk_i && top_open) begin
            win_o = 1'b1;
            vec_o = VECW'(VEC_BRK);
            lvl_o = LVLW'(LMAX);
        end else if (dbg_i && top_open) begin
            win_o = 1'b1;
            vec_o = VECW'(VEC_DBG);
            lvl_o = LVLW'(LMAX);
        end else if (found && (best_lvl > mask_i)) begin
            win_o = 1'b1;
            vec_o = best_vec;
            lvl_o = best_lvl;
            clr_o = best_clr;
        end
    end

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
    parameter int NSRC     = 4,
    parameter int LVLW     = 4,
    parameter int VECW     = 8,
    parameter int VEC_NMI  = 11,
    parameter int VEC_BRK  = 12,
    parameter int VEC_DBG  = 13,
    parameter int VEC_BASE = 64
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      mrst_i,
    input  logic                      nmi_i,
    input  logic                      brk_i,
    input  logic                      dbg_i,
    input  logic [NSRC-1:0]           src_i,
    input  logic [NSRC-1:0]           src_edge_i,
    input  logic [NSRC-1:0][LVLW-1:0] src_prio_i,
    input  logic                      mask_we_i,
    input  logic [LVLW-1:0]           mask_wdata_i,
    input  logic                      cpu_ack_i,
    output logic                      cpu_req_o,
    output logic                      irq_n_o,
    output logic [VECW-1:0]           vec_o,
    output logic [LVLW-1:0]           lvl_o,
    output logic [LVLW-1:0]           mask_o,
    output logic [2:0]                phase_o
);

    import pic_pkg::*;

    localparam int NLAT = NSRC + 1;
    localparam int LMAX = (1 << LVLW) - 1;

    typedef struct packed {
        phase_e          phase;
        logic [LVLW-1:0] mask;
        logic [VECW-1:0] vec;
        logic [LVLW-1:0] lvl;
        logic [NLAT-1:0] clr;
    } regs_t;

    regs_t r_d, r_q;

    logic [NLAT-1:0] lat_pend;
    logic [NLAT-1:0] lat_clr;
    logic [LVLW-1:0] eff_mask;
    logic            win;
    logic [VECW-1:0] win_vec;
    logic [LVLW-1:0] win_lvl;
    logic [NLAT-1:0] win_clr;
    logic            accept;

    for (genvar g = 0; g < NLAT; g++) begin : g_lat
        if (g < NSRC) begin : g_src
            pic_edge_latch u_lat (
                .clk       (clk),
                .rst_n     (rst_n),
                .mrst_i    (mrst_i),
                .in_i      (src_i[g]),
                .is_edge_i (src_edge_i[g]),
                .clr_i     (lat_clr[g]),
                .pend_o    (lat_pend[g])
            );
        end else begin : g_nmi
            pic_edge_latch u_lat (
                .clk       (clk),
                .rst_n     (rst_n),
                .mrst_i    (mrst_i),
                .in_i      (nmi_i),
                .is_edge_i (1'b1),
                .clr_i     (lat_clr[g]),
                .pend_o    (lat_pend[g])
            );
        end
    end

    assign eff_mask = mask_we_i ? mask_wdata_i : r_q.mask;

    pic_arbiter #(
        .NSRC     (NSRC),
        .LVLW     (LVLW),
        .VECW     (VECW),
        .VEC_NMI  (VEC_NMI),
        .VEC_BRK  (VEC_BRK),
        .VEC_DBG  (VEC_DBG),
        .VEC_BASE (VEC_BASE)
    ) u_arb (
        .nmi_i  (lat_pend[NSRC]),
        .brk_i  (brk_i),
        .dbg_i  (dbg_i),
        .pend_i (lat_pend[NSRC-1:0]),
        .prio_i (src_prio_i),
        .mask_i (eff_mask),
        .win_o  (win),
        .vec_o  (win_vec),
        .lvl_o  (win_lvl),
        .clr_o  (win_clr)
    );

    assign accept  = (r_q.phase == PH_PEND) && cpu_ack_i;
    assign lat_clr = accept ? r_q.clr : '0;

    always_comb begin
        r_d = r_q;
        if (mask_we_i) begin
            r_d.mask = mask_wdata_i;
        end
        unique case (r_q.phase)
            PH_IDLE: begin
                if (win) begin
                    r_d.phase = PH_PEND;
                    r_d.vec   = win_vec;
                    r_d.lvl   = win_lvl;
                    r_d.clr   = win_clr;
                end
            end
            PH_PEND: begin
                if (cpu_ack_i) begin
                    r_d.phase = PH_SAVE_SR;
                    r_d.mask  = r_q.lvl;
                end else if (win) begin
                    r_d.vec = win_vec;
                    r_d.lvl = win_lvl;
                    r_d.clr = win_clr;
                end else begin
                    r_d.phase = PH_IDLE;
                end
            end
            PH_SAVE_SR: if (cpu_ack_i) r_d.phase = PH_SAVE_PC;
            PH_SAVE_PC: if (cpu_ack_i) r_d.phase = PH_FETCH;
            PH_FETCH:   if (cpu_ack_i) r_d.phase = PH_BRANCH;
            PH_BRANCH:  if (cpu_ack_i) r_d.phase = PH_IDLE;
            default:    r_d.phase = PH_IDLE;
        endcase
        if (mrst_i) begin
            r_d       = '0;
            r_d.phase = PH_IDLE;
            r_d.mask  = LVLW'(LMAX);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.phase <= PH_IDLE;
            r_q.mask  <= LVLW'(LMAX);
        end else begin
            r_q <= r_d;
        end
    end

    assign cpu_req_o = (r_q.phase == PH_PEND);
    assign irq_n_o   = (r_q.phase != PH_PEND);
    assign vec_o     = r_q.vec;
    assign lvl_o     = r_q.lvl;
    assign mask_o    = r_q.mask;
    assign phase_o   = r_q.phase;

endmodule

// File: rtl/pic_chk.sv
module pic_chk #(
    parameter int LVLW    = 4,
    parameter int VECW    = 8,
    parameter int VEC_NMI = 11
) (
    input logic            clk,
    input logic            rst_n,
    input logic            mrst_i,
    input logic            cpu_ack_i,
    input logic            cpu_req_o,
    input logic            irq_n_o,
    input logic [VECW-1:0] vec_o,
    input logic [LVLW-1:0] lvl_o,
    input logic [LVLW-1:0] mask_o,
    input logic [2:0]      phase_o
);

    // R6
    pend_ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n || mrst_i)
        (phase_o == 3'd1 && cpu_ack_i) |=> (irq_n_o && phase_o == 3'd2));

    // R4
    mask_copy_chk: assert property (@(posedge clk) disable iff (!rst_n || mrst_i)
        (phase_o == 3'd1 && cpu_ack_i) |=> (mask_o == $past(lvl_o)));

    // R3
    req_beats_mask_chk: assert property (@(posedge clk) disable iff (!rst_n || mrst_i)
        (cpu_req_o && vec_o != VECW'(VEC_NMI)) |-> (lvl_o > mask_o));

    // R5
    step_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || mrst_i)
        (phase_o >= 3'd2 && !cpu_ack_i) |=> $stable(phase_o));

    // R12
    no_zero_level_chk: assert property (@(posedge clk) disable iff (!rst_n || mrst_i)
        cpu_req_o |-> (lvl_o != '0));

endmodule

bind prio_irq_ctrl pic_chk #(
    .LVLW    (LVLW),
    .VECW    (VECW),
    .VEC_NMI (VEC_NMI)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .mrst_i    (mrst_i),
    .cpu_ack_i (cpu_ack_i),
    .cpu_req_o (cpu_req_o),
    .irq_n_o   (irq_n_o),
    .vec_o     (vec_o),
    .lvl_o     (lvl_o),
    .mask_o    (mask_o),
    .phase_o   (phase_o)
);

// File: tb/prio_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module prio_irq_ctrl_tb_top;

    localparam int NSRC = 4;
    localparam int LVLW = 4;
    localparam int VECW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mrst = 1'b0;
    logic nmi = 1'b0, brk = 1'b0, dbg = 1'b0;
    logic [NSRC-1:0] src = '0;
    logic [NSRC-1:0] sedge = '0;
    logic [NSRC-1:0][LVLW-1:0] sprio = '0;
    logic mwe = 1'b0;
    logic [LVLW-1:0] mwd = '0;
    logic ack = 1'b0;
    logic cpu_req, irq_n;
    logic [VECW-1:0] vec;
    logic [LVLW-1:0] lvl, mask;
    logic [2:0] phase;

    int n_vec = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    prio_irq_ctrl #(.NSRC(NSRC), .LVLW(LVLW), .VECW(VECW)) dut_i (
        .clk(clk), .rst_n(rst_n), .mrst_i(mrst),
        .nmi_i(nmi), .brk_i(brk), .dbg_i(dbg),
        .src_i(src), .src_edge_i(sedge), .src_prio_i(sprio),
        .mask_we_i(mwe), .mask_wdata_i(mwd), .cpu_ack_i(ack),
        .cpu_req_o(cpu_req), .irq_n_o(irq_n), .vec_o(vec), .lvl_o(lvl),
        .mask_o(mask), .phase_o(phase)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic setmask(input int v);
        mwe = 1'b1;
        mwd = LVLW'(v);
        cyc(1);
        mwe = 1'b0;
    endtask

    task automatic ack1();
        ack = 1'b1;
        cyc(1);
        ack = 1'b0;
    endtask

    task automatic ack_all();
        repeat (5) ack1();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL R5 watchdog act=running exp=done");
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        chk("R6 reset req", int'(cpu_req), 0);
        chk("R6 reset irq_n", int'(irq_n), 1);
        chk("R4 reset mask", int'(mask), 15);
        chk("R5 reset phase", int'(phase), 0);

        // R3 / R12 / R9: sweep mask against level on a level-sensed source
        for (int m = 0; m < 16; m++) begin
            for (int l = 0; l < 16; l++) begin
                sprio[0] = LVLW'(l);
                src[0] = 1'b1;
                setmask(m);
                cyc(1);
                chk(l == 0 ? "R12 level0 req" : "R3 mask compare req", int'(cpu_req), (l > m) ? 1 : 0);
                chk("R6 irq_n tracks req", int'(irq_n), (l > m) ? 0 : 1);
                src[0] = 1'b0;
                cyc(1);
                chk("R9 level drop", int'(cpu_req), 0);
                cyc(1);
            end
        end

        // R2: non-maskable with mask 15, full handshake
        setmask(15);
        nmi = 1'b1;
        cyc(1);
        nmi = 1'b0;
        cyc(1);
        chk("R2 nmi offered", int'(cpu_req), 1);
        chk("R11 nmi vector", int'(vec), 11);
        chk("R6 irq_n low", int'(irq_n), 0);
        ack1();
        chk("R5 phase save sr", int'(phase), 2);
        chk("R6 irq_n released", int'(irq_n), 1);
        chk("R4 mask after nmi", int'(mask), 15);
        ack1();
        chk("R5 phase save pc", int'(phase), 3);
        cyc(2);
        chk("R5 phase holds", int'(phase), 3);
        ack1();
        chk("R5 phase fetch", int'(phase), 4);
        ack1();
        chk("R5 phase branch", int'(phase), 5);
        ack1();
        chk("R5 phase idle", int'(phase), 0);
        cyc(1);
        chk("R8 nmi latch cleared", int'(cpu_req), 0);

        // R1 / R7: all at once, break wins first then nmi takes over
        setmask(0);
        sprio[1] = 4'd15;
        nmi = 1'b1; brk = 1'b1; dbg = 1'b1; src[1] = 1'b1;
        cyc(1);
        chk("R1 break before nmi latch", int'(vec), 12);
        nmi = 1'b0;
        cyc(1);
        chk("R1 nmi first", int'(vec), 11);
        chk("R7 irq_n held low", int'(irq_n), 0);
        ack_all();
        cyc(1);
        chk("R3 break masked at 15", int'(cpu_req), 0);
        setmask(0);
        cyc(1);
        chk("R1 break second", int'(vec), 12);
        ack_all();
        brk = 1'b0;
        setmask(0);
        cyc(1);
        chk("R1 debug third", int'(vec), 13);
        ack_all();
        dbg = 1'b0;
        setmask(0);
        cyc(1);
        chk("R11 source vector", int'(vec), 65);
        chk("R1 maskable level", int'(lvl), 15);
        ack_all();
        chk("R4 mask after level 15", int'(mask), 15);
        src[1] = 1'b0;

        // R4: level 9 copy
        sprio[2] = 4'd9;
        src[2] = 1'b1;
        setmask(3);
        cyc(1);
        chk("R11 src2 vector", int'(vec), 66);
        chk("R4 shown level", int'(lvl), 9);
        ack1();
        chk("R4 mask copy", int'(mask), 9);
        repeat (4) ack1();
        cyc(1);
        chk("R3 equal level blocked", int'(cpu_req), 0);
        src[2] = 1'b0;
        cyc(1);

        // R7: stronger level source takes over
        sprio[1] = 4'd3;
        src[1] = 1'b1;
        setmask(0);
        cyc(1);
        chk("R7 first winner", int'(vec), 65);
        src[2] = 1'b1;
        cyc(1);
        chk("R7 takeover vector", int'(vec), 66);
        chk("R7 takeover level", int'(lvl), 9);
        chk("R7 irq_n stays low", int'(irq_n), 0);
        src = '0;
        cyc(1);
        chk("R9 drop to idle", int'(cpu_req), 0);

        // R10: ties
        sprio = {4'd5, 4'd5, 4'd5, 4'd5};
        src[0] = 1'b1; src[3] = 1'b1;
        cyc(1);
        chk("R10 tie lowest index", int'(vec), 64);
        src[0] = 1'b0;
        cyc(1);
        chk("R10 remaining source", int'(vec), 67);
        src = '0;
        sprio[1] = 4'd7; sprio[2] = 4'd7;
        src[1] = 1'b1; src[2] = 1'b1;
        cyc(1);
        chk("R10 tie pair", int'(vec), 65);
        src = '0;
        cyc(2);

        // R8: edge latching and clearing
        sedge[2] = 1'b1;
        sprio[2] = 4'd6;
        src[2] = 1'b1;
        cyc(1);
        src[2] = 1'b0;
        cyc(3);
        chk("R8 latched after drop", int'(cpu_req), 1);
        chk("R8 latched vector", int'(vec), 66);
        mrst = 1'b1;
        cyc(1);
        mrst = 1'b0;
        chk("R8 manual reset idle", int'(cpu_req), 0);
        chk("R4 manual reset mask", int'(mask), 15);
        setmask(0);
        cyc(1);
        chk("R8 manual reset cleared", int'(cpu_req), 0);
        src[2] = 1'b1;
        cyc(1);
        src[2] = 1'b0;
        cyc(1);
        chk("R8 relatched", int'(cpu_req), 1);
        ack_all();
        chk("R4 mask after edge", int'(mask), 6);
        setmask(0);
        cyc(1);
        chk("R8 ack cleared", int'(cpu_req), 0);
        src[2] = 1'b1;
        cyc(1);
        src[2] = 1'b0;
        cyc(1);
        rst_n = 1'b0;
        cyc(1);
        rst_n = 1'b1;
        cyc(1);
        setmask(0);
        cyc(1);
        chk("R8 power-on cleared", int'(cpu_req), 0);

        // R13 / R5
        setmask(7);
        chk("R13 mask write", int'(mask), 7);
        ack1();
        chk("R5 ack in idle ignored", int'(phase), 0);

        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule